// File: doc/BRIEF.md
# Addend-Tuned PTP Time Counter

This block keeps a free-running time of day for IEEE 1588 work. A 32-bit phase accumulator adds a programmable fractional step, the addend, on every reference clock. Each carry out of the accumulator advances a 64-bit tick count by one, and one tick stands for 32 ns. Software converts ticks to nanoseconds with a 5-bit shift. Software trims the clock frequency by moving the addend up or down in proportion to the ppm error that its servo measures.

Software reaches the block over a simple word-addressed register bus with 32-bit data. Reads and writes of the 64-bit time go through two halves in a fixed order: low word first, then high word. A low read freezes the matching high word. A low write is only staged, and the high write commits both halves in one cycle. The low word wraps at a programmable limit that is guarded by an unlock bit. A 64-bit target compare raises a sticky pending flag, which software clears by writing one to it. A control bit holds the whole timekeeping path in reset for as long as it stays set.

Top module: `ptp_tod_counter`

## Requirements
- R1: Outside soft reset, every clock edge sets the accumulator to (accumulator + addend) mod 2^32. A carry out of bit 31 advances the tick count by one in that same edge. With addend 0x80000000 and a cleared accumulator, the count gains one tick on every second edge.
- R2: The addend register (offset 2) reads 0xA0000000 after reset. A write to it is used from the next edge on.
- R3: Read data appears one cycle after the read strobe. A read of offset 3 returns the low time word and captures the high word at the same time. A read of offset 4 returns that captured word, however far the count has moved since.
- R4: A write to offset 3 only stages the low word and leaves the time unchanged. A write to offset 4 loads {written word, staged word} into the time, clears the accumulator, and overrides any carry in that edge.
- R5: Control register (offset 0) bit 0 is a soft reset. While it reads 1, the time is 0, the accumulator is 0, pending is 0, the addend returns to 0xA0000000 and the wrap limit returns to 0x7FFFFFFF. Time and addend writes are ignored during that period, and counting resumes once the bit is cleared.
- R6: When a tick arrives and the low word is at or above the wrap limit, the low word goes to 0 and the high word increments. The limit resets to 0x7FFFFFFF.
- R7: The wrap limit (offset 8) accepts writes only while unlock bit 0 of offset 7 is 1, and ignores them otherwise. With the limit at 0xFFFFFFFF, the low word runs through its full range into the high word.
- R8: Pending (event register offset 1, bit 1, also driven on `target_irq`) becomes 1 one edge after time >= the 64-bit target (low word at offset 5, high word at offset 6, reset all ones). It stays set until cleared by writing 1 to bit 1. If the compare still holds in the same edge as the clear, the set wins.
- R9: Writing 0 to event bit 1, or writing only other event bits, leaves pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, data valid next cycle |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tod_ticks | output | 64 | Current time in 32 ns ticks |
| target_irq | output | 1 | Target-reached pending flag |

## Verification
A wrong accumulator or addend shows up on `tod_ticks` within two clock edges, as a tick that arrives early or late against an independent per-edge reference. A stale or missing capture register is caught by a high-word read taken after the count has crossed a word boundary. A bad staging path appears on the port in the cycle right after the high-word write. A pending flag that misses the one-edge latency, the set-over-clear priority or the write-one-to-clear rule is visible on `target_irq` in the very next cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL    = 4'd0,
    REG_EVENT   = 4'd1,
    REG_ADDEND  = 4'd2,
    REG_TIME_LO = 4'd3,
    REG_TIME_HI = 4'd4,
    REG_TGT_LO  = 4'd5,
    REG_TGT_HI  = 4'd6,
    REG_LIM_EN  = 4'd7,
    REG_LIM     = 4'd8
  } tod_reg_e;

  localparam int CTRL_SRST_BIT = 0;
  localparam int EVT_TGT_BIT   = 1;
  localparam int LIMEN_BIT     = 0;
endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
  parameter int          ACC_W       = 32,
  parameter logic [ACC_W-1:0] ADDEND_INIT = 32'hA000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             clr_acc,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic [ACC_W-1:0] addend_q,
  output logic             carry
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  function automatic logic [ACC_W:0] phase_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum   = phase_add(acc_q, addend_q);
  assign carry = sum[ACC_W] & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= ADDEND_INIT;
    end else if (soft_rst) begin
      acc_q    <= '0;
      addend_q <= ADDEND_INIT;
    end else begin
      acc_q <= clr_acc ? '0 : sum[ACC_W-1:0];
      if (addend_we) addend_q <= addend_wdata;
    end
  end
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg #(
  parameter int               HALF_W        = 32,
  parameter logic [HALF_W-1:0] LO_LIMIT_INIT = 32'h7FFF_FFFF,
  localparam int              TOD_W         = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              stage_we,
  input  logic              commit_we,
  input  logic              lim_en_we,
  input  logic              lim_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [TOD_W-1:0]  tod_q,
  output logic [HALF_W-1:0] stage_q,
  output logic [HALF_W-1:0] lim_q,
  output logic              lim_en_q,
  output logic              lo_wrap
);
  function automatic logic [TOD_W-1:0] tick_next(input logic [TOD_W-1:0] t,
                                                 input logic [HALF_W-1:0] lim);
    if (t[HALF_W-1:0] >= lim)
      return {t[TOD_W-1:HALF_W] + HALF_W'(1), {HALF_W{1'b0}}};
    else
      return t + TOD_W'(1);
  endfunction

  assign lo_wrap = tod_q[HALF_W-1:0] >= lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q   <= '0;
      stage_q <= '0;
      lim_q   <= LO_LIMIT_INIT;
    end else if (soft_rst) begin
      tod_q   <= '0;
      stage_q <= '0;
      lim_q   <= LO_LIMIT_INIT;
    end else begin
      if (commit_we)  tod_q <= {wdata, stage_q};
      else if (tick)  tod_q <= tick_next(tod_q, lim_q);
      if (stage_we)   stage_q <= wdata;
      if (lim_we && lim_en_q) lim_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lim_en_q <= 1'b0;
    else if (lim_en_we) lim_en_q <= wdata[tod_pkg::LIMEN_BIT];
  end
endmodule

// File: rtl/tod_target_cmp.sv
module tod_target_cmp #(
  parameter int  HALF_W = 32,
  localparam int TOD_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tgt_lo_we,
  input  logic              tgt_hi_we,
  input  logic              clr_req,
  input  logic [HALF_W-1:0] wdata,
  input  logic [TOD_W-1:0]  tod,
  output logic [TOD_W-1:0]  tgt_q,
  output logic              hit,
  output logic              pend_q
);
  function automatic logic reached(input logic [TOD_W-1:0] now,
                                   input logic [TOD_W-1:0] tgt);
    return now >= tgt;
  endfunction

  assign hit = reached(tod, tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '1;
    end else begin
      if (tgt_lo_we) tgt_q[HALF_W-1:0]     <= wdata;
      if (tgt_hi_we) tgt_q[TOD_W-1:HALF_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (soft_rst) pend_q <= 1'b0;
    else               pend_q <= (pend_q & ~clr_req) | hit;
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int                ACC_W         = 32,
  parameter int                HALF_W        = 32,
  parameter logic [ACC_W-1:0]  ADDEND_INIT   = 32'hA000_0000,
  parameter logic [HALF_W-1:0] LO_LIMIT_INIT = 32'h7FFF_FFFF,
  localparam int               TOD_W         = 2 * HALF_W,
  localparam int               AW            = tod_pkg::REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic [TOD_W-1:0]  tod_ticks,
  output logic              target_irq
);
  import tod_pkg::*;

  logic              ctrl_q;
  logic              we_ctrl, we_event, we_addend, we_lo, we_hi;
  logic              we_tgt_lo, we_tgt_hi, we_lim_en, we_lim;
  logic              commit, carry, lo_wrap, hit, pend, lim_en;
  logic              evt_clr;
  logic [ACC_W-1:0]  addend;
  logic [TOD_W-1:0]  tod, tgt;
  logic [HALF_W-1:0] stage, lim, shadow_q, rd_mux;

  assign we_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign we_event  = bus_wr && (bus_addr == REG_EVENT);
  assign we_addend = bus_wr && (bus_addr == REG_ADDEND);
  assign we_lo     = bus_wr && (bus_addr == REG_TIME_LO);
  assign we_hi     = bus_wr && (bus_addr == REG_TIME_HI);
  assign we_tgt_lo = bus_wr && (bus_addr == REG_TGT_LO);
  assign we_tgt_hi = bus_wr && (bus_addr == REG_TGT_HI);
  assign we_lim_en = bus_wr && (bus_addr == REG_LIM_EN);
  assign we_lim    = bus_wr && (bus_addr == REG_LIM);
  assign commit    = we_hi;
  assign evt_clr   = we_event && bus_wdata[EVT_TGT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (we_ctrl) ctrl_q <= bus_wdata[CTRL_SRST_BIT];
  end

  tod_phase_acc #(.ACC_W(ACC_W), .ADDEND_INIT(ADDEND_INIT)) u_acc (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctrl_q), .clr_acc(commit),
    .addend_we(we_addend), .addend_wdata(bus_wdata[ACC_W-1:0]),
    .addend_q(addend), .carry(carry)
  );

  tod_time_reg #(.HALF_W(HALF_W), .LO_LIMIT_INIT(LO_LIMIT_INIT)) u_time (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctrl_q), .tick(carry),
    .stage_we(we_lo), .commit_we(commit), .lim_en_we(we_lim_en),
    .lim_we(we_lim), .wdata(bus_wdata), .tod_q(tod), .stage_q(stage),
    .lim_q(lim), .lim_en_q(lim_en), .lo_wrap(lo_wrap)
  );

  tod_target_cmp #(.HALF_W(HALF_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctrl_q), .tgt_lo_we(we_tgt_lo),
    .tgt_hi_we(we_tgt_hi), .clr_req(evt_clr), .wdata(bus_wdata),
    .tod(tod), .tgt_q(tgt), .hit(hit), .pend_q(pend)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CTRL:    rd_mux = HALF_W'(ctrl_q);
      REG_EVENT:   rd_mux = HALF_W'(pend) << EVT_TGT_BIT;
      REG_ADDEND:  rd_mux = HALF_W'(addend);
      REG_TIME_LO: rd_mux = tod[HALF_W-1:0];
      REG_TIME_HI: rd_mux = shadow_q;
      REG_TGT_LO:  rd_mux = tgt[HALF_W-1:0];
      REG_TGT_HI:  rd_mux = tgt[TOD_W-1:HALF_W];
      REG_LIM_EN:  rd_mux = HALF_W'(lim_en);
      REG_LIM:     rd_mux = lim;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      shadow_q  <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
      if (bus_addr == REG_TIME_LO) shadow_q <= tod[TOD_W-1:HALF_W];
    end
  end

  assign tod_ticks  = tod;
  assign target_irq = pend;
endmodule

// File: rtl/tod_counter_checker.sv
module tod_counter_checker #(
  parameter int  HALF_W = 32,
  localparam int TOD_W  = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_q,
  input logic              commit,
  input logic              tick,
  input logic              lo_wrap,
  input logic              hit,
  input logic              pend,
  input logic              lim_en,
  input logic [HALF_W-1:0] lim,
  input logic [HALF_W-1:0] stage,
  input logic [HALF_W-1:0] wdata,
  input logic [TOD_W-1:0]  tod
);
  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit && !lo_wrap) |=> tod == $past(tod) + TOD_W'(1));

  assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit && !soft_q) |=> tod == $past(tod));

  assert_commit_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !soft_q) |=> tod == {$past(wdata), $past(stage)});

  assert_soft_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> (tod == '0) && !pend);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit && lo_wrap) |=>
      (tod[HALF_W-1:0] == '0) &&
      (tod[TOD_W-1:HALF_W] == $past(tod[TOD_W-1:HALF_W]) + HALF_W'(1)));

  assert_lim_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_en && !soft_q) |=> lim == $past(lim));

  assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !soft_q) |=> pend);
endmodule

bind ptp_tod_counter tod_counter_checker #(.HALF_W(HALF_W)) u_tod_chk (
  .clk(clk), .rst_n(rst_n), .soft_q(ctrl_q), .commit(commit), .tick(carry),
  .lo_wrap(lo_wrap), .hit(hit), .pend(pend), .lim_en(lim_en), .lim(lim),
  .stage(stage), .wdata(bus_wdata), .tod(tod)
);

// File: tb/test_ptp_tod_counter.sv
module test_ptp_tod_counter;
  import tod_pkg::*;

  localparam logic [31:0] ADD_INIT = 32'hA000_0000;
  localparam logic [31:0] LIM_INIT = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] tod_ticks;
  logic        target_irq;

  int n_chk = 0, n_bad = 0;
  bit run_cmp = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  ptp_tod_counter i_ptp_tod_counter (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tod_ticks(tod_ticks), .target_irq(target_irq)
  );

  // reference state, advanced once per rising edge from the requirements
  logic        m_ctrl, m_limen, m_pend;
  logic [31:0] m_acc, m_add, m_stage, m_lim, m_shadow, m_rdata;
  logic [63:0] m_tod, m_tgt;

  function automatic logic [63:0] ref_tick(input logic [63:0] t, input logic [31:0] lim);
    if (t[31:0] >= lim) return {t[63:32] + 32'd1, 32'd0};
    return t + 64'd1;
  endfunction

  always @(posedge clk) begin : ref_model
    logic [32:0] s;
    logic        np;
    if (!rst_n) begin
      m_ctrl = 0; m_limen = 0; m_pend = 0; m_acc = 0; m_add = ADD_INIT;
      m_stage = 0; m_lim = LIM_INIT; m_shadow = 0; m_rdata = 0;
      m_tod = 0; m_tgt = '1;
    end else begin
      s  = {1'b0, m_acc} + {1'b0, m_add};
      np = m_ctrl ? 1'b0 :
           ((m_pend && !(bus_wr && bus_addr == REG_EVENT && bus_wdata[1])) || (m_tod >= m_tgt));
      if (bus_rd) begin
        case (bus_addr)
          REG_CTRL:    m_rdata = {31'd0, m_ctrl};
          REG_EVENT:   m_rdata = {30'd0, m_pend, 1'b0};
          REG_ADDEND:  m_rdata = m_add;
          REG_TIME_LO: begin m_rdata = m_tod[31:0]; m_shadow = m_tod[63:32]; end
          REG_TIME_HI: m_rdata = m_shadow;
          REG_TGT_LO:  m_rdata = m_tgt[31:0];
          REG_TGT_HI:  m_rdata = m_tgt[63:32];
          REG_LIM_EN:  m_rdata = {31'd0, m_limen};
          REG_LIM:     m_rdata = m_lim;
          default:     m_rdata = 0;
        endcase
      end
      m_pend = np;
      if (m_ctrl) begin
        m_acc = 0; m_tod = 0; m_add = ADD_INIT; m_lim = LIM_INIT; m_stage = 0;
      end else begin
        if (bus_wr && bus_addr == REG_TIME_HI) begin
          m_tod = {bus_wdata, m_stage}; m_acc = 0;
        end else begin
          m_acc = s[31:0];
          if (s[32]) m_tod = ref_tick(m_tod, m_lim);
        end
        if (bus_wr && bus_addr == REG_ADDEND)  m_add = bus_wdata;
        if (bus_wr && bus_addr == REG_TIME_LO) m_stage = bus_wdata;
        if (bus_wr && bus_addr == REG_LIM && m_limen) m_lim = bus_wdata;
      end
      if (bus_wr && bus_addr == REG_CTRL)   m_ctrl  = bus_wdata[0];
      if (bus_wr && bus_addr == REG_LIM_EN) m_limen = bus_wdata[0];
      if (bus_wr && bus_addr == REG_TGT_LO) m_tgt[31:0]  = bus_wdata;
      if (bus_wr && bus_addr == REG_TGT_HI) m_tgt[63:32] = bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // every cycle: time and pending against the reference (R1, R8)
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R1 tod_ticks vs reference", tod_ticks, m_tod);
      chk("R8 target_irq vs reference", 64'(target_irq), 64'(m_pend));
    end
  end

  initial begin : watchdog
    #(8 * 120000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic [63:0] base;
    void'($urandom(32'h0000_1588));
    repeat (3) @(negedge clk);
    chk("R1 reset tod", tod_ticks, 64'd0);
    chk("R8 reset irq", 64'(target_irq), 64'd0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    bus_read(REG_ADDEND, rd); chk("R2 addend reset", 64'(rd), 64'(ADD_INIT));
    bus_read(REG_LIM, rd);    chk("R6 limit reset", 64'(rd), 64'(LIM_INIT));

    // R4 staging and commit, then R1 closed-form rate
    bus_write(REG_ADDEND, 32'h0);
    base = tod_ticks;
    bus_write(REG_TIME_LO, 32'h100);
    chk("R4 low write only stages", tod_ticks, base);
    bus_write(REG_TIME_HI, 32'h0);
    chk("R4 high write commits", tod_ticks, 64'h100);
    bus_write(REG_ADDEND, 32'h8000_0000);
    chk("R2 addend used next edge", tod_ticks, 64'h100);
    repeat (20) @(negedge clk);
    chk("R1 half-rate count", tod_ticks, 64'h10A);

    // R6 default wrap point
    bus_write(REG_ADDEND, 32'h0);
    bus_write(REG_TIME_LO, 32'h7FFF_FFF0);
    bus_write(REG_TIME_HI, 32'h2);
    bus_write(REG_ADDEND, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    chk("R6 high word after wrap", 64'(tod_ticks[63:32]), 64'd3);
    chk("R6 low word restarted", 64'(tod_ticks[31:0] < 32'd40), 64'd1);

    // R7 limit lock
    bus_write(REG_LIM, 32'h1234);
    bus_read(REG_LIM, rd); chk("R7 locked write ignored", 64'(rd), 64'(LIM_INIT));
    bus_write(REG_LIM_EN, 32'h1);
    bus_write(REG_LIM, 32'hFFFF_FFFF);
    bus_write(REG_LIM_EN, 32'h0);
    bus_read(REG_LIM, rd); chk("R7 unlocked write taken", 64'(rd), 64'hFFFF_FFFF);

    // R3 capture of high word, R7 full-range wrap
    bus_write(REG_ADDEND, 32'h0);
    bus_write(REG_TIME_LO, 32'hFFFF_FFF0);
    bus_write(REG_TIME_HI, 32'h7);
    bus_write(REG_ADDEND, 32'hFFFF_FFFF);
    bus_read(REG_TIME_LO, rd); chk("R3 low word read", 64'(rd), 64'(m_rdata));
    repeat (40) @(negedge clk);
    chk("R7 full-range carry", 64'(tod_ticks[63:32]), 64'd8);
    bus_read(REG_TIME_HI, rd); chk("R3 captured high word", 64'(rd), 64'd7);

    // R8 and R9 target compare
    bus_write(REG_ADDEND, 32'h0);
    bus_write(REG_TIME_LO, 32'd100);
    bus_write(REG_TIME_HI, 32'd0);
    bus_write(REG_TGT_LO, 32'd100);
    chk("R8 no pending below target", 64'(target_irq), 64'd0);
    bus_write(REG_TGT_HI, 32'd0);
    chk("R8 one edge latency", 64'(target_irq), 64'd0);
    @(negedge clk);
    chk("R8 pending set", 64'(target_irq), 64'd1);
    bus_write(REG_EVENT, 32'h2);
    chk("R8 set wins over clear", 64'(target_irq), 64'd1);
    bus_read(REG_EVENT, rd); chk("R8 event readback", 64'(rd), 64'h2);
    bus_write(REG_TGT_HI, 32'd1);
    chk("R8 pending sticky", 64'(target_irq), 64'd1);
    bus_write(REG_EVENT, 32'hFFFF_FFFD);
    chk("R9 zero in bit 1 keeps pending", 64'(target_irq), 64'd1);
    bus_read(REG_EVENT, rd); chk("R9 event unchanged", 64'(rd), 64'h2);
    bus_write(REG_EVENT, 32'h2);
    chk("R8 write-one clears", 64'(target_irq), 64'd0);

    // R5 soft reset
    bus_write(REG_TGT_HI, 32'd0);
    @(negedge clk);
    bus_write(REG_CTRL, 32'h1);
    bus_write(REG_ADDEND, 32'h1234);
    bus_write(REG_TIME_LO, 32'h5);
    bus_write(REG_TIME_HI, 32'h5);
    chk("R5 time held at zero", tod_ticks, 64'd0);
    chk("R5 pending cleared", 64'(target_irq), 64'd0);
    bus_write(REG_TGT_HI, 32'hFFFF_FFFF);
    bus_write(REG_CTRL, 32'h0);
    bus_read(REG_ADDEND, rd); chk("R5 addend restored", 64'(rd), 64'(ADD_INIT));
    bus_read(REG_LIM, rd);    chk("R5 limit restored", 64'(rd), 64'(LIM_INIT));
    bus_read(REG_CTRL, rd);   chk("R5 control readback", 64'(rd), 64'd0);
    repeat (20) @(negedge clk);
    chk("R5 counting resumed", 64'(tod_ticks != 64'd0), 64'd1);

    // random mix against the reference
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = 4'($urandom % 9);
      d = $urandom;
      if (a == REG_CTRL && ($urandom % 6) != 0) a = REG_ADDEND;
      if (a == REG_ADDEND && ($urandom % 2) == 0) d = 32'hA000_0000 + ($urandom % 32'h0100_0000);
      if (a == REG_TIME_LO && ($urandom % 2) == 0) d = 32'h7FFF_FF00 + ($urandom % 256);
      if ($urandom % 2 == 0) begin
        bus_write(a, d);
      end else begin
        bus_read(a, rd);
        chk("R3 random read vs reference", 64'(rd), 64'(m_rdata));
      end
      if (m_ctrl && ($urandom % 3) == 0) bus_write(REG_CTRL, 32'h0);
    end
    bus_write(REG_CTRL, 32'h0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule